// File: doc/BRIEF.md
# Word Shifter with Carry and Extend

This block shifts a 32-bit operand by a 6-bit count taken from a register, in one of three modes: logical left, logical right and arithmetic right. It returns the shifted word with carry (C) and extend (X) flags, plus negative (N) and zero (Z) flags taken from the result. The overflow flag (V) is always 0. The carry from the previous operation is an input, so a zero-count shift can pass it through unchanged.

Each request is a single-cycle operation. `in_valid` starts a request. One clock edge later, all outputs are registered and `out_valid` is high. The count is taken modulo 64, and every count from 32 to 63 has a defined result and carry.

Top module: `wshift_top`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `res`, `c_flag`, `x_flag`, `n_flag`, `z_flag` and `v_flag` are all 0.
- R2: The results of a request sampled with `in_valid` high appear one clock edge later, with `out_valid` high. `out_valid` is low in every cycle that follows a cycle with `in_valid` low.
- R3: Only the low 6 bits of `count` are used. Count bits above bit 5 have no effect.
- R4: When the effective count is 0, the result equals the operand and C equals `c_prev`, in every mode.
- R5: Mode 2'b00 (logical left) with count n in 1..31 gives the operand shifted left by n and C = operand bit (32-n). With n = 32 the result is 0 and C = operand bit 0. With n above 32 the result is 0 and C = 0.
- R6: Mode 2'b01 (logical right) with count n in 1..31 gives the operand shifted right with zero fill and C = operand bit (n-1). With n = 32 the result is 0 and C = operand bit 31. With n above 32 the result is 0 and C = 0.
- R7: Mode 2'b10 (arithmetic right) with count n in 1..31 gives a sign-filled shift and C = operand bit (n-1). With n of 32 or more, every result bit equals operand bit 31, and so does C.
- R8: Mode 2'b11 passes the operand through unchanged with C = `c_prev`, whatever the count.
- R9: X equals C after every operation, including zero-count operations.
- R10: N equals result bit 31, Z is 1 exactly when the result is 0, and V is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 pass-through |
| count | input | 8 | Shift count; only the low 6 bits are used |
| operand | input | 32 | Value to shift |
| c_prev | input | 1 | Carry from the previous operation |
| out_valid | output | 1 | Result valid |
| res | output | 32 | Shifted result |
| c_flag | output | 1 | Carry |
| x_flag | output | 1 | Extend, a copy of the carry |
| n_flag | output | 1 | Negative |
| z_flag | output | 1 | Zero |
| v_flag | output | 1 | Overflow, always 0 |

## Verification
The assertions compare each registered output with the inputs sampled one cycle earlier, through `$past`. They therefore assume `mode`, `count`, `operand` and `c_prev` are settled at the edge where `in_valid` is high, and they ignore those inputs when `in_valid` is low. The bench drives all inputs half a period away from the capturing edge and changes them only between edges. It also covers every mode code, including the spare one. The counts it uses cover 0, 1, 31, 32, 33 and 63, plus counts with the upper count bits set.

// File: rtl/wshift_pkg.sv
package wshift_pkg;
  typedef enum logic [1:0] {
    SH_LEFT  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_ARITH = 2'b10,
    SH_PASS  = 2'b11
  } sh_mode_e;
endpackage

// File: rtl/wshift_core.sv
module wshift_core
  import wshift_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic [1:0]  mode,
  input  logic [CW-1:0] cnt,
  input  logic [W-1:0]  opnd,
  input  logic          cin,
  output logic [W-1:0]  result,
  output logic          cout
);
  localparam logic [CW-1:0] WCNT = CW'(W);
  logic [2*W-1:0] ext_l;
  logic [2*W-1:0] ext_r;
  logic [2*W:0]   fill_r;
  logic           sgn;

  assign sgn = opnd[W-1];

  always_comb begin
    result = opnd;
    cout   = cin;
    ext_l  = '0;
    ext_r  = '0;
    fill_r = '0;
    if (cnt != '0) begin
      case (sh_mode_e'(mode))
        SH_LEFT: begin
          ext_l = {{W{1'b0}}, opnd} << cnt;
          if (cnt < WCNT) begin
            result = ext_l[W-1:0];
            cout   = ext_l[W];
          end else if (cnt == WCNT) begin
            result = '0;
            cout   = opnd[0];
          end else begin
            result = '0;
            cout   = 1'b0;
          end
        end
        SH_RIGHT: begin
          ext_r = {opnd, {W{1'b0}}} >> cnt;
          if (cnt <= WCNT) begin
            result = ext_r[2*W-1:W];
            cout   = ext_r[W-1];
          end else begin
            result = '0;
            cout   = 1'b0;
          end
        end
        SH_ARITH: begin
          fill_r = $signed({sgn, opnd, {W{1'b0}}}) >>> cnt;
          if (cnt < WCNT) begin
            result = fill_r[2*W-1:W];
            cout   = fill_r[W-1];
          end else begin
            result = {W{sgn}};
            cout   = sgn;
          end
        end
        default: begin
          result = opnd;
          cout   = cin;
        end
      endcase
    end
  end
endmodule

// File: rtl/wshift_flags.sv
module wshift_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] result,
  output logic         neg,
  output logic         zero
);
  assign neg  = result[W-1];
  assign zero = (result == '0);
endmodule

// File: rtl/wshift_top.sv
module wshift_top
  import wshift_pkg::*;
#(
  parameter int W   = 32,
  parameter int CNW = 8,
  parameter int CW  = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [1:0]     mode,
  input  logic [CNW-1:0] count,
  input  logic [W-1:0]   operand,
  input  logic           c_prev,
  output logic           out_valid,
  output logic [W-1:0]   res,
  output logic           c_flag,
  output logic           x_flag,
  output logic           n_flag,
  output logic           z_flag,
  output logic           v_flag
);
  logic [W-1:0] sh_res;
  logic         sh_c;
  logic         f_n;
  logic         f_z;

  wshift_core #(.W(W), .CW(CW)) u_core (
    .mode(mode), .cnt(count[CW-1:0]), .opnd(operand), .cin(c_prev),
    .result(sh_res), .cout(sh_c)
  );

  wshift_flags #(.W(W)) u_flags (.result(sh_res), .neg(f_n), .zero(f_z));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res       <= '0;
      c_flag    <= 1'b0;
      x_flag    <= 1'b0;
      n_flag    <= 1'b0;
      z_flag    <= 1'b0;
      v_flag    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      v_flag    <= 1'b0;
      if (in_valid) begin
        res    <= sh_res;
        c_flag <= sh_c;
        x_flag <= sh_c;
        n_flag <= f_n;
        z_flag <= f_z;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && count[CW-1:0] == '0) |=> (res == $past(operand) && c_flag == $past(c_prev))); // R4
  AST_PASS_MODE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b11) |=> (res == $past(operand) && c_flag == $past(c_prev))); // R8
  AST_X_FOLLOWS_C: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> x_flag == c_flag); // R9
  AST_V_LOW: assert property (@(posedge clk) disable iff (rst)
    v_flag == 1'b0); // R10
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (z_flag == (res == '0)) && (n_flag == res[W-1])); // R10
  AST_LEFT_BIG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00 && count[CW-1:0] > CW'(W)) |=> (res == '0 && !c_flag)); // R5
  AST_ARITH_BIG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b10 && count[CW-1:0] >= CW'(W)) |=> (res == {W{$past(operand[W-1])}})); // R7
endmodule

// File: tb/sim_wshift_top.sv
module sim_wshift_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [7:0]  count = 8'd0;
  logic [31:0] operand = 32'd0;
  logic        c_prev = 1'b0;
  logic        out_valid, c_flag, x_flag, n_flag, z_flag, v_flag;
  logic [31:0] res;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] r; logic c; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  wshift_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .count(count),
    .operand(operand), .c_prev(c_prev), .out_valid(out_valid), .res(res),
    .c_flag(c_flag), .x_flag(x_flag), .n_flag(n_flag), .z_flag(z_flag),
    .v_flag(v_flag)
  );

  function automatic exp_t model(input logic [1:0] m, input logic [7:0] cn,
                                 input logic [31:0] v, input logic cp, input string t);
    exp_t e;
    int n;
    n = int'(cn[5:0]);
    e.tag = t; e.r = v; e.c = cp;
    if (n != 0 && m != 2'b11) begin
      if (m == 2'b00) begin
        if (n < 32) begin e.r = v << n; e.c = v[32-n]; end
        else if (n == 32) begin e.r = 0; e.c = v[0]; end
        else begin e.r = 0; e.c = 0; end
      end else if (m == 2'b01) begin
        if (n < 32) begin e.r = v >> n; e.c = v[n-1]; end
        else if (n == 32) begin e.r = 0; e.c = v[31]; end
        else begin e.r = 0; e.c = 0; end
      end else begin
        if (n < 32) begin e.r = 32'($signed(v) >>> n); e.c = v[n-1]; end
        else begin e.r = {32{v[31]}}; e.c = v[31]; end
      end
    end
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic [7:0] cn,
                       input logic [31:0] v, input logic cp, input string t);
    @(negedge clk);
    in_valid = 1'b1; mode = m; count = cn; operand = v; c_prev = cp;
    q.push_back(model(m, cn, v, cp, t));
  endtask

  // monitor: outputs for a request appear one edge after capture
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2 act=unexpected out_valid exp=none");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " res"}, res, e.r);
        chk({e.tag, " C"}, {31'd0, c_flag}, {31'd0, e.c});
        chk("R9 X", {31'd0, x_flag}, {31'd0, e.c});
        chk("R10 N", {31'd0, n_flag}, {31'd0, e.r[31]});
        chk("R10 Z", {31'd0, z_flag}, {31'd0, e.r == 0});
        chk("R10 V", {31'd0, v_flag}, 32'd0);
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 valid", {31'd0, out_valid}, 32'd0);
    chk("R1 res", res, 32'd0);
    chk("R1 flags", {26'd0, c_flag, x_flag, n_flag, z_flag, v_flag, 1'b0}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 idle", {31'd0, out_valid}, 32'd0);
    // R4 zero count
    drive(2'b00, 8'd0, 32'h8000_0001, 1'b1, "R4");
    drive(2'b10, 8'd0, 32'h1234_5678, 1'b0, "R4");
    drive(2'b01, 8'd64, 32'hF000_000F, 1'b1, "R3");
    // R5 left
    drive(2'b00, 8'd1, 32'h8000_0001, 1'b0, "R5");
    drive(2'b00, 8'd31, 32'h0000_0003, 1'b0, "R5");
    drive(2'b00, 8'd32, 32'h0000_0001, 1'b0, "R5");
    drive(2'b00, 8'd33, 32'hFFFF_FFFF, 1'b1, "R5");
    drive(2'b00, 8'd63, 32'hFFFF_FFFF, 1'b1, "R5");
    // R6 logical right
    drive(2'b01, 8'd1, 32'h8000_0001, 1'b0, "R6");
    drive(2'b01, 8'd31, 32'hC000_0000, 1'b0, "R6");
    drive(2'b01, 8'd32, 32'h8000_0000, 1'b0, "R6");
    drive(2'b01, 8'd40, 32'hFFFF_FFFF, 1'b1, "R6");
    // R7 arithmetic right
    drive(2'b10, 8'd4, 32'h8000_0018, 1'b0, "R7");
    drive(2'b10, 8'd31, 32'h4000_0000, 1'b0, "R7");
    drive(2'b10, 8'd32, 32'h8000_0000, 1'b0, "R7");
    drive(2'b10, 8'd63, 32'h7FFF_FFFF, 1'b1, "R7");
    // R3 upper count bits ignored
    drive(2'b00, 8'hC4, 32'h0000_00F1, 1'b0, "R3");
    drive(2'b10, 8'h81, 32'h8000_0003, 1'b0, "R3");
    // R8 spare mode
    drive(2'b11, 8'd5, 32'hDEAD_BEEF, 1'b1, "R8");
    drive(2'b11, 8'd40, 32'h0000_0000, 1'b0, "R8");
    // sweep
    for (int i = 0; i < 64; i++) begin
      drive(2'(i % 3), 8'(i), 32'hA5C3_0F96 ^ (32'(i) * 32'h0101_0101), 1'(i & 1), "R5 R6 R7 sweep");
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 drained", {31'd0, out_valid}, 32'd0);
    chk("R2 queue", 32'(q.size()), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule